// File: doc/BRIEF.md
# CPU interrupt input pin conditioner

This block is the front end that sits between a processor core and the six interrupt-related lines that reach it: external interrupt, system-management interrupt, machine check, checkstop, hard reset and soft reset. Lines are presented one at a time as indexed level updates (`evt_valid`, `evt_pin`, `evt_level`). The block keeps a registered copy of every line's last level and reacts only when an update really changes that level, so a source that repeats the same level produces no event.

From these changes the block maintains a four-bit pending vector for the core, a halt flag, a one-cycle reset request and a single hard-interrupt request line that summarises the pending vector. External interrupt, system-management interrupt and soft reset are level sensitive and active high. Machine check is negative-edge sensitive, and its pending bit stays set until the core clears it with a strobe. Checkstop holds the core halted while it is asserted.

Top module: `icond_top`

## Requirements
- R1: An update whose level equals the stored level of that line causes no action: no pending bit, halt or reset request changes.
- R2: Line 0 (external interrupt) is level sensitive and active high; its stored level is copied into `pend[0]`.
- R3: Line 1 (system-management interrupt) is level sensitive and active high; its stored level is copied into `pend[1]`.
- R4: Line 2 (machine check) sets `pend[2]` on a 1-to-0 change of its level; a 0-to-1 change leaves `pend[2]` alone.
- R5: `pend[2]` stays set until `mck_clr` is high at a clock edge; when a machine-check falling change and `mck_clr` come in the same cycle, the bit ends up set.
- R6: Line 3 (checkstop) drives `halt`: a change to 1 sets it and a change to 0 clears it.
- R7: A 0-to-1 change of line 4 (hard reset) makes `reset_req` high for exactly the one cycle after that edge; a 1-to-0 change produces no request.
- R8: Line 5 (soft reset) is level sensitive and its stored level is copied into `pend[3]`.
- R9: An update with an index of 6 or above is ignored: `pin_state` and all other outputs keep their values.
- R10: `hard_irq` is high exactly when any pending bit is set; with `HREQ_REG` = 1 it follows the pending vector one cycle later, with `HREQ_REG` = 0 in the same cycle.
- R11: After reset `pin_state`, `pend`, `halt`, `reset_req` and `hard_irq` are all zero; every update is taken on the rising clock edge where `evt_valid` is high, and `pin_state[i]` shows the stored level of line i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_valid | input | 1 | An update of one line is presented this cycle |
| evt_pin | input | IDX_W | Index of the line being updated (0..5 known) |
| evt_level | input | 1 | New level of the indexed line |
| mck_clr | input | 1 | Clear strobe for the sticky machine-check pending bit |
| pin_state | output | 6 | Stored last level of every line |
| pend | output | 4 | Pending vector: 0 external, 1 system-management, 2 machine check, 3 soft reset |
| halt | output | 1 | Core halted by checkstop |
| reset_req | output | 1 | One-cycle core reset request |
| hard_irq | output | 1 | Summary request: any pending bit set |

## Verification
The bench builds the block with `IDX_W` = 3 and `HREQ_REG` = 1. The three-bit index makes codes 6 and 7 reachable, so the handling of unknown lines is exercised at the ports. The registered summary variant adds a cycle of lag between the pending vector and `hard_irq`, and the bench predicts that lag from the previous vector's expected pending value. A mid-run reset with pending state present checks that everything returns to zero.

// File: rtl/icond_pkg.sv
package icond_pkg;
   // Line indices; the order is decoded by the action stage.
   localparam int LINE_EXT  = 0;
   localparam int LINE_SMI  = 1;
   localparam int LINE_MCK  = 2;
   localparam int LINE_CSTP = 3;
   localparam int LINE_HRST = 4;
   localparam int LINE_SRST = 5;
   localparam int LINE_N    = 6;

   // Pending vector bit positions.
   localparam int PND_EXT = 0;
   localparam int PND_SMI = 1;
   localparam int PND_MCK = 2;
   localparam int PND_RST = 3;
   localparam int PND_N   = 4;
endpackage

// File: rtl/icond_track.sv
module icond_track
   import icond_pkg::*;
#(
   parameter int IDX_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_valid,
   input  logic [IDX_W-1:0]  evt_pin,
   input  logic              evt_level,
   output logic [LINE_N-1:0] lvl_q,
   output logic [LINE_N-1:0] chg
);
   // One change strobe per known line; unknown indices match none.
   for (genvar i = 0; i < LINE_N; i++) begin : g_line
      logic hit;
      assign hit    = evt_valid && (evt_pin == IDX_W'(i));
      assign chg[i] = hit && (evt_level != lvl_q[i]);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      lvl_q[i] <= 1'b0;
         else if (chg[i]) lvl_q[i] <= evt_level;
      end
   end
endmodule

// File: rtl/icond_action.sv
module icond_action
   import icond_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LINE_N-1:0] chg,
   input  logic              evt_level,
   input  logic              mck_clr,
   output logic [PND_N-1:0]  pend_q,
   output logic              halt_q,
   output logic              rreq_q
);
   logic mck_fall;
   logic hrst_rise;

   assign mck_fall  = chg[LINE_MCK]  && !evt_level;
   assign hrst_rise = chg[LINE_HRST] &&  evt_level;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         halt_q <= 1'b0;
         rreq_q <= 1'b0;
      end else begin
         if (chg[LINE_EXT])  pend_q[PND_EXT] <= evt_level;
         if (chg[LINE_SMI])  pend_q[PND_SMI] <= evt_level;
         if (chg[LINE_SRST]) pend_q[PND_RST] <= evt_level;
         // Set has priority over the clear strobe.
         if (mck_fall)       pend_q[PND_MCK] <= 1'b1;
         else if (mck_clr)   pend_q[PND_MCK] <= 1'b0;
         if (chg[LINE_CSTP]) halt_q <= evt_level;
         rreq_q <= hrst_rise;
      end
   end
endmodule

// File: rtl/icond_hreq.sv
module icond_hreq
   import icond_pkg::*;
#(
   parameter bit HREQ_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PND_N-1:0] pend,
   output logic             hard_irq
);
   logic any_pend;
   assign any_pend = |pend;

   if (HREQ_REG) begin : g_reg
      logic hreq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) hreq_q <= 1'b0;
         else        hreq_q <= any_pend;
      end
      assign hard_irq = hreq_q;
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign hard_irq   = any_pend;
   end
endmodule

// File: rtl/icond_top.sv
module icond_top
   import icond_pkg::*;
#(
   parameter int IDX_W    = 3,
   parameter bit HREQ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_valid,
   input  logic [IDX_W-1:0]  evt_pin,
   input  logic              evt_level,
   input  logic              mck_clr,
   output logic [LINE_N-1:0] pin_state,
   output logic [PND_N-1:0]  pend,
   output logic              halt,
   output logic              reset_req,
   output logic              hard_irq
);
   if (IDX_W < $clog2(LINE_N)) begin : g_bad_idx
      $error("icond_top: IDX_W too narrow to address every line");
   end

   logic [LINE_N-1:0] chg;

   icond_track #(.IDX_W(IDX_W)) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_valid (evt_valid),
      .evt_pin   (evt_pin),
      .evt_level (evt_level),
      .lvl_q     (pin_state),
      .chg       (chg)
   );

   icond_action u_action (
      .clk       (clk),
      .rst_n     (rst_n),
      .chg       (chg),
      .evt_level (evt_level),
      .mck_clr   (mck_clr),
      .pend_q    (pend),
      .halt_q    (halt),
      .rreq_q    (reset_req)
   );

   icond_hreq #(.HREQ_REG(HREQ_REG)) u_hreq (
      .clk      (clk),
      .rst_n    (rst_n),
      .pend     (pend),
      .hard_irq (hard_irq)
   );
endmodule

// File: rtl/icond_chk.sv
module icond_chk
   import icond_pkg::*;
#(
   parameter int IDX_W    = 3,
   parameter bit HREQ_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              evt_valid,
   input logic [IDX_W-1:0]  evt_pin,
   input logic              evt_level,
   input logic              mck_clr,
   input logic [LINE_N-1:0] pin_state,
   input logic [PND_N-1:0]  pend,
   input logic              halt,
   input logic              reset_req,
   input logic              hard_irq
);
   // R1
   quiet_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !evt_valid |=> $stable(pin_state));
   // R2
   ext_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend[PND_EXT] == pin_state[LINE_EXT]);
   // R3
   smi_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend[PND_SMI] == pin_state[LINE_SMI]);
   // R4
   mck_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && evt_pin == IDX_W'(LINE_MCK) && !evt_level && pin_state[LINE_MCK])
      |=> pend[PND_MCK]);
   // R5
   mck_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[PND_MCK] && !mck_clr) |=> pend[PND_MCK]);
   // R6
   halt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halt == pin_state[LINE_CSTP]);
   // R7
   rreq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req |-> $rose(pin_state[LINE_HRST]));
   // R8
   srst_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend[PND_RST] == pin_state[LINE_SRST]);
   // R9
   unknown_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && evt_pin >= IDX_W'(LINE_N) && !mck_clr)
      |=> ($stable(pin_state) && $stable(pend) && $stable(halt)));

   if (HREQ_REG) begin : g_reg_chk
      // R10
      hreq_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
         hard_irq == $past(|pend));
   end else begin : g_comb_chk
      // R10
      hreq_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
         hard_irq == (|pend));
   end
endmodule

bind icond_top icond_chk #(.IDX_W(IDX_W), .HREQ_REG(HREQ_REG)) u_chk (.*);

// File: tb/test_icond_top.sv
module test_icond_top;
   localparam int IDX_W = 3;
   localparam int NV    = 23;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             evt_valid = 1'b0;
   logic [IDX_W-1:0] evt_pin = '0;
   logic             evt_level = 1'b0;
   logic             mck_clr = 1'b0;
   logic [5:0]       pin_state;
   logic [3:0]       pend;
   logic             halt;
   logic             reset_req;
   logic             hard_irq;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   icond_top #(.IDX_W(IDX_W), .HREQ_REG(1'b1)) i_icond_top (
      .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_pin(evt_pin),
      .evt_level(evt_level), .mck_clr(mck_clr), .pin_state(pin_state),
      .pend(pend), .halt(halt), .reset_req(reset_req), .hard_irq(hard_irq)
   );

   // {valid, pin[3], level, clr, exp_pins[6], exp_pend[4], exp_halt, exp_rreq}
   localparam logic [17:0] VEC [NV] = '{
      {1'b1, 3'd0, 1'b1, 1'b0, 6'b000001, 4'b0001, 1'b0, 1'b0}, // R2 ext on
      {1'b1, 3'd0, 1'b1, 1'b0, 6'b000001, 4'b0001, 1'b0, 1'b0}, // R1 repeat
      {1'b1, 3'd1, 1'b1, 1'b0, 6'b000011, 4'b0011, 1'b0, 1'b0}, // R3 smi on
      {1'b1, 3'd0, 1'b0, 1'b0, 6'b000010, 4'b0010, 1'b0, 1'b0}, // R2 ext off
      {1'b1, 3'd1, 1'b0, 1'b0, 6'b000000, 4'b0000, 1'b0, 1'b0}, // R3 smi off
      {1'b1, 3'd2, 1'b1, 1'b0, 6'b000100, 4'b0000, 1'b0, 1'b0}, // R4 rise
      {1'b1, 3'd2, 1'b0, 1'b0, 6'b000000, 4'b0100, 1'b0, 1'b0}, // R4 fall
      {1'b1, 3'd2, 1'b0, 1'b0, 6'b000000, 4'b0100, 1'b0, 1'b0}, // R1 repeat
      {1'b0, 3'd0, 1'b0, 1'b1, 6'b000000, 4'b0000, 1'b0, 1'b0}, // R5 clear
      {1'b1, 3'd2, 1'b0, 1'b0, 6'b000000, 4'b0000, 1'b0, 1'b0}, // R1 no refire
      {1'b1, 3'd3, 1'b1, 1'b0, 6'b001000, 4'b0000, 1'b1, 1'b0}, // R6 halt
      {1'b1, 3'd3, 1'b0, 1'b0, 6'b000000, 4'b0000, 1'b0, 1'b0}, // R6 resume
      {1'b1, 3'd4, 1'b1, 1'b0, 6'b010000, 4'b0000, 1'b0, 1'b1}, // R7 request
      {1'b1, 3'd4, 1'b1, 1'b0, 6'b010000, 4'b0000, 1'b0, 1'b0}, // R7 one cycle
      {1'b1, 3'd4, 1'b0, 1'b0, 6'b000000, 4'b0000, 1'b0, 1'b0}, // R7 fall none
      {1'b1, 3'd5, 1'b1, 1'b0, 6'b100000, 4'b1000, 1'b0, 1'b0}, // R8 on
      {1'b1, 3'd6, 1'b1, 1'b0, 6'b100000, 4'b1000, 1'b0, 1'b0}, // R9 code 6
      {1'b1, 3'd7, 1'b1, 1'b0, 6'b100000, 4'b1000, 1'b0, 1'b0}, // R9 code 7
      {1'b1, 3'd5, 1'b0, 1'b0, 6'b000000, 4'b0000, 1'b0, 1'b0}, // R8 off
      {1'b0, 3'd0, 1'b0, 1'b0, 6'b000000, 4'b0000, 1'b0, 1'b0}, // R10 idle
      {1'b1, 3'd2, 1'b1, 1'b0, 6'b000100, 4'b0000, 1'b0, 1'b0}, // R4 rise
      {1'b1, 3'd2, 1'b0, 1'b1, 6'b000000, 4'b0100, 1'b0, 1'b0}, // R5 set wins
      {1'b0, 3'd0, 1'b0, 1'b1, 6'b000000, 4'b0000, 1'b0, 1'b0}  // R5 clear
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step(input logic v, input logic [IDX_W-1:0] p, input logic l, input logic c);
      evt_valid = v; evt_pin = p; evt_level = l; mck_clr = c;
      @(negedge clk);
      evt_valid = 1'b0; mck_clr = 1'b0;
   endtask

   initial begin
      logic prev_any;
      repeat (3) @(negedge clk);
      // R11 reset state
      check("R11 pins", 32'(pin_state), 32'd0);
      check("R11 pend", 32'(pend), 32'd0);
      check("R11 flags", {29'd0, halt, reset_req, hard_irq}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      prev_any = 1'b0;
      for (int k = 0; k < NV; k++) begin
         logic [17:0] e;
         e = VEC[k];
         step(e[17], e[16:14], e[13], e[12]);
         check($sformatf("R11 pins v%0d", k), 32'(pin_state), 32'(e[11:6]));
         check($sformatf("R2/R3/R4/R5/R8 pend v%0d", k), 32'(pend), 32'(e[5:2]));
         check($sformatf("R6 halt v%0d", k), 32'(halt), 32'(e[1]));
         check($sformatf("R7 reset_req v%0d", k), 32'(reset_req), 32'(e[0]));
         check($sformatf("R10 hard_irq v%0d", k), 32'(hard_irq), 32'(prev_any));
         prev_any = |e[5:2];
      end
      // R10 directed: summary rises one cycle after the pending bit
      step(1'b1, 3'd1, 1'b1, 1'b0);
      check("R10 lag low", 32'(hard_irq), 32'd0);
      step(1'b0, 3'd0, 1'b0, 1'b0);
      check("R10 lag high", 32'(hard_irq), 32'd1);
      // R11 mid-run reset with state present
      step(1'b1, 3'd3, 1'b1, 1'b0);
      rst_n = 1'b0;
      @(negedge clk);
      check("R11 rerst pins", 32'(pin_state), 32'd0);
      check("R11 rerst pend", 32'(pend), 32'd0);
      check("R11 rerst flags", {29'd0, halt, reset_req, hard_irq}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #(10 * 100000);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule